// File: doc/BRIEF.md
# Bulk Endpoint Transmit/Receive Segmenter

This block sits behind a device-side bulk endpoint and turns a single transfer request, given as a total byte count, into a series of data packets no larger than the configured maximum payload. For every packet it presents the payload length and the data PID. It then waits for a per-packet result: an acknowledge, an error, a timeout or a stall. The DATA0/DATA1 toggle is held across transfers. It advances only when a packet is acknowledged. Endpoint configuration and clearing a halt both return it to DATA0.

A transfer ends in one of three ways: the requested count has been moved exactly, a packet shorter than the maximum (including a zero-length packet) has been sent or received, or something aborts it. A stall ends the transfer and leaves the endpoint halted until a clear-halt strobe. In receive direction, a payload longer than the expected length of the current packet also aborts the transfer. An optional mode appends a zero-length packet when a nonzero transmit length is an exact multiple of the maximum payload. Requests that arrive with an illegal size/speed pairing, in low-speed mode, while halted or while a transfer is in progress are refused.

Top module: `bulk_tx_segmenter`

## Requirements
- R1: After reset no packet is offered (pkt_valid low), pkt_pid shows DATA0, halted is low and done_pulse, abort_pulse and req_rej are low.
- R2: cfg_err is high unless speed is full (2'b01) with max_pkt of 8, 16, 32 or 64, or speed is high (2'b10) with max_pkt of 512. Low speed (2'b00) and the reserved code (2'b11) always flag cfg_err. A request made while cfg_err is high, while halted, or while a transfer is active gives a one-cycle req_rej and starts nothing.
- R3: While a transfer is active, pkt_len equals the smaller of the bytes still outstanding and the maximum payload latched at request time. Every packet before the last is full size, and no packet is padded.
- R4: When an acknowledged full-size packet leaves zero bytes outstanding, done_pulse rises for one cycle and pkt_valid drops. This applies to receive transfers, and to transmit transfers with zero-length append off.
- R5: In receive direction (req_rx high), an acknowledge whose res_len is below the maximum payload and not above pkt_len completes the transfer with done_pulse.
- R6: With zlp_en set on a transmit request whose length is a nonzero multiple of the maximum payload, one extra packet of length 0 follows the last full packet. Its acknowledge completes the transfer. A transmit request of length 0 yields a single zero-length packet.
- R7: pkt_pid is 4'b0011 for DATA0 and 4'b1011 for DATA1. An acknowledge flips it. A result code of error (2'b01) or timeout (2'b10) leaves pkt_pid, pkt_len and the outstanding count unchanged, so the same packet is offered again.
- R8: A cfg_stb or clr_halt_stb sets the toggle to DATA0 and clears halted.
- R9: A stall result (2'b11) during a transfer gives a one-cycle abort_pulse, ends the transfer and sets halted. Later requests are refused until clr_halt_stb or cfg_stb. The acknowledge code is 2'b00.
- R10: In receive direction, an acknowledge with res_len greater than pkt_len aborts the transfer with abort_pulse and leaves the toggle unchanged.
- R11: A result presented while no transfer is active has no effect: no pulse, toggle and halted unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed | input | 2 | Bus speed: 00 low, 01 full, 10 high, 11 reserved |
| max_pkt | input | MPS_W | Maximum payload size in bytes |
| zlp_en | input | 1 | Append a zero-length packet after an exact-multiple transmit |
| cfg_stb | input | 1 | Endpoint configured: toggle to DATA0, halt cleared |
| clr_halt_stb | input | 1 | Clear halt: toggle to DATA0, halt cleared |
| req_valid | input | 1 | Transfer request strobe |
| req_rx | input | 1 | Request direction: 1 receive, 0 transmit |
| req_len | input | LEN_W | Total transfer length in bytes |
| res_valid | input | 1 | Packet result strobe |
| res_code | input | 2 | 00 ack, 01 error, 10 timeout, 11 stall |
| res_len | input | MPS_W | Received payload length (receive direction) |
| cfg_err | output | 1 | Current speed/max_pkt pairing is illegal |
| halted | output | 1 | Endpoint halted after a stall |
| pkt_valid | output | 1 | A packet is being offered |
| pkt_len | output | MPS_W | Payload length of the offered packet |
| pkt_pid | output | 4 | Data PID of the offered packet |
| done_pulse | output | 1 | Transfer completed |
| abort_pulse | output | 1 | Transfer aborted by stall or oversize payload |
| req_rej | output | 1 | Request refused |

## Verification
cfg_err is combinational and is checked in the same cycle as the speed and size inputs. Every other output is registered. pkt_len and pkt_pid for the next packet, and the done, abort and reject pulses, are due at the first rising edge after the stimulus. The bench drives each stimulus on a falling edge for exactly one cycle and compares on the next falling edge, which lands half a period after the edge that updates the outputs. A pulse is therefore checked in its only high cycle, and the following packet's length and PID are checked before the next result is driven.

// File: rtl/bulk_seg_pkg.sv
package bulk_seg_pkg;
    localparam logic [1:0] SPD_LOW  = 2'b00;
    localparam logic [1:0] SPD_FULL = 2'b01;
    localparam logic [1:0] SPD_HIGH = 2'b10;

    localparam logic [1:0] RES_ACK   = 2'b00;
    localparam logic [1:0] RES_ERR   = 2'b01;
    localparam logic [1:0] RES_TMO   = 2'b10;
    localparam logic [1:0] RES_STALL = 2'b11;

    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    localparam int FS_SIZES = 4;
    localparam int FS_MIN   = 8;
    localparam int HS_SIZE  = 512;
endpackage

// File: rtl/bulk_seg_size_check.sv
module bulk_seg_size_check
    import bulk_seg_pkg::*;
#(
    parameter int MPS_W = 11
) (
    input  logic [1:0]       speed,
    input  logic [MPS_W-1:0] mps,
    output logic             legal
);
    logic [FS_SIZES-1:0] fs_hit;

    for (genvar i = 0; i < FS_SIZES; i++) begin : g_fs
        assign fs_hit[i] = (mps == MPS_W'(FS_MIN << i));
    end

    always_comb begin
        case (speed)
            SPD_FULL: legal = |fs_hit;
            SPD_HIGH: legal = (mps == MPS_W'(HS_SIZE));
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bulk_seg_pkt_len.sv
module bulk_seg_pkt_len #(
    parameter int LEN_W = 16,
    parameter int MPS_W = 11
) (
    input  logic [LEN_W-1:0] remain,
    input  logic [MPS_W-1:0] mps,
    output logic [MPS_W-1:0] len
);
    localparam int PAD_W = LEN_W - MPS_W;

    logic [LEN_W-1:0] mps_ext;

    assign mps_ext = {{PAD_W{1'b0}}, mps};
    assign len     = (remain < mps_ext) ? remain[MPS_W-1:0] : mps;
endmodule

// File: rtl/bulk_tx_segmenter.sv
module bulk_tx_segmenter
    import bulk_seg_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int MPS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       speed,
    input  logic [MPS_W-1:0] max_pkt,
    input  logic             zlp_en,
    input  logic             cfg_stb,
    input  logic             clr_halt_stb,
    input  logic             req_valid,
    input  logic             req_rx,
    input  logic [LEN_W-1:0] req_len,
    input  logic             res_valid,
    input  logic [1:0]       res_code,
    input  logic [MPS_W-1:0] res_len,
    output logic             cfg_err,
    output logic             halted,
    output logic             pkt_valid,
    output logic [MPS_W-1:0] pkt_len,
    output logic [3:0]       pkt_pid,
    output logic             done_pulse,
    output logic             abort_pulse,
    output logic             req_rej
);
    typedef struct packed {
        logic             active;
        logic             rx;
        logic             zlp;
        logic             tog;
        logic             halted;
        logic             done;
        logic             abort;
        logic             rej;
        logic [LEN_W-1:0] remain;
        logic [MPS_W-1:0] mps;
    } seg_state_t;

    seg_state_t s_d, s_q;

    logic             size_ok;
    logic [MPS_W-1:0] cur_len;
    logic [MPS_W-1:0] xfer_len;
    logic [LEN_W-1:0] rem_after;

    bulk_seg_size_check #(.MPS_W(MPS_W)) u_size (
        .speed (speed),
        .mps   (max_pkt),
        .legal (size_ok)
    );

    bulk_seg_pkt_len #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_len (
        .remain (s_q.remain),
        .mps    (s_q.mps),
        .len    (cur_len)
    );

    assign xfer_len  = s_q.rx ? res_len : cur_len;
    assign rem_after = s_q.remain - LEN_W'(xfer_len);

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.abort = 1'b0;
        s_d.rej   = 1'b0;

        // Per-packet result
        if (s_q.active && res_valid) begin
            case (res_code)
                RES_ACK: begin
                    if (s_q.rx && (res_len > cur_len)) begin
                        s_d.active = 1'b0;
                        s_d.abort  = 1'b1;
                    end else begin
                        s_d.tog    = ~s_q.tog;
                        s_d.remain = rem_after;
                        if (xfer_len < s_q.mps) begin
                            s_d.active = 1'b0;
                            s_d.done   = 1'b1;
                        end else if ((rem_after == '0) && !(s_q.zlp && !s_q.rx)) begin
                            s_d.active = 1'b0;
                            s_d.done   = 1'b1;
                        end
                    end
                end
                RES_STALL: begin
                    s_d.active = 1'b0;
                    s_d.abort  = 1'b1;
                    s_d.halted = 1'b1;
                end
                default: ;
            endcase
        end

        // New transfer request
        if (req_valid) begin
            if (!s_q.active && !s_q.halted && size_ok && (speed != SPD_LOW)) begin
                s_d.active = 1'b1;
                s_d.rx     = req_rx;
                s_d.zlp    = zlp_en;
                s_d.remain = req_len;
                s_d.mps    = max_pkt;
            end else begin
                s_d.rej = 1'b1;
            end
        end

        // Configuration or clear-halt restart the toggle
        if (cfg_stb || clr_halt_stb) begin
            s_d.tog    = 1'b0;
            s_d.halted = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_err     = ~size_ok;
    assign halted      = s_q.halted;
    assign pkt_valid   = s_q.active;
    assign pkt_len     = s_q.active ? cur_len : '0;
    assign pkt_pid     = s_q.tog ? PID_DATA1 : PID_DATA0;
    assign done_pulse  = s_q.done;
    assign abort_pulse = s_q.abort;
    assign req_rej     = s_q.rej;
endmodule

// File: rtl/bulk_seg_checker.sv
module bulk_seg_checker
    import bulk_seg_pkg::*;
#(
    parameter int MPS_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_stb,
    input logic             clr_halt_stb,
    input logic             req_valid,
    input logic             res_valid,
    input logic [1:0]       res_code,
    input logic             cfg_err,
    input logic             halted,
    input logic             pkt_valid,
    input logic [MPS_W-1:0] pkt_len,
    input logic [3:0]       pkt_pid,
    input logic             done_pulse,
    input logic             abort_pulse,
    input logic             req_rej
);
    // R7: only the two data PID codes ever appear
    p_pid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_pid == PID_DATA0) || (pkt_pid == PID_DATA1));

    // R7: error/timeout re-offers the identical packet
    p_retry_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && res_valid && (res_code == RES_ERR || res_code == RES_TMO)
         && !cfg_stb && !clr_halt_stb)
        |=> (pkt_valid && $stable(pkt_len) && $stable(pkt_pid)));

    // R7, R10: an acknowledge flips the toggle unless the payload was oversize
    p_ack_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && res_valid && res_code == RES_ACK && !cfg_stb && !clr_halt_stb)
        |=> (abort_pulse || (pkt_pid != $past(pkt_pid))));

    // R9: a stall aborts, ends the transfer and halts the endpoint
    p_stall_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && res_valid && res_code == RES_STALL && !cfg_stb && !clr_halt_stb)
        |=> (abort_pulse && halted && !pkt_valid));

    // R8: clear-halt returns to DATA0 and un-halts
    p_clear_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_halt_stb |=> (pkt_pid == PID_DATA0 && !halted));

    // R2: an illegal size/speed request is refused
    p_bad_cfg_rej_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_err && !pkt_valid) |=> (req_rej && !pkt_valid));

    // R11: results while idle produce nothing
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && res_valid) |=> (!done_pulse && !abort_pulse));

    // R4, R9: completion and abort are exclusive
    p_end_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && abort_pulse));
endmodule

bind bulk_tx_segmenter bulk_seg_checker #(.MPS_W(MPS_W)) u_chk (.*);

// File: tb/bulk_tx_segmenter_test.sv
`timescale 1ns/1ps
module bulk_tx_segmenter_test;
    localparam int LEN_W = 16;
    localparam int MPS_W = 11;
    localparam logic [3:0] D0 = 4'b0011;
    localparam logic [3:0] D1 = 4'b1011;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       speed = 2'b01;
    logic [MPS_W-1:0] max_pkt = MPS_W'(64);
    logic             zlp_en = 1'b0;
    logic             cfg_stb = 1'b0;
    logic             clr_halt_stb = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_rx = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             res_valid = 1'b0;
    logic [1:0]       res_code = 2'b00;
    logic [MPS_W-1:0] res_len = '0;
    logic             cfg_err, halted, pkt_valid, done_pulse, abort_pulse, req_rej;
    logic [MPS_W-1:0] pkt_len;
    logic [3:0]       pkt_pid;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_tog = 1'b0;

    always #2.5 clk = ~clk;

    bulk_tx_segmenter #(.LEN_W(LEN_W), .MPS_W(MPS_W)) uut (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int exp_len(input int rem, input int mps);
        return (rem < mps) ? rem : mps;
    endfunction

    function automatic logic [3:0] exp_pid(input bit t);
        return t ? D1 : D0;
    endfunction

    function automatic bit exp_legal(input logic [1:0] sp, input int mps);
        if (sp == 2'b01) return (mps == 8 || mps == 16 || mps == 32 || mps == 64);
        if (sp == 2'b10) return (mps == 512);
        return 1'b0;
    endfunction

    task automatic request(input logic [1:0] sp, input int mps, input int len,
                           input bit zlp, input bit rx);
        speed = sp; max_pkt = MPS_W'(mps); zlp_en = zlp; req_rx = rx;
        req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic result(input logic [1:0] code, input int rl);
        res_valid = 1'b1; res_code = code; res_len = MPS_W'(rl);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic strobe_clr(input bit cfg);
        if (cfg) cfg_stb = 1'b1; else clr_halt_stb = 1'b1;
        @(negedge clk);
        cfg_stb = 1'b0; clr_halt_stb = 1'b0;
        exp_tog = 1'b0;
    endtask

    // Full transfer against the bench model; rnd enables random retries/short rx
    task automatic run_xfer(input logic [1:0] sp, input int mps, input int len,
                            input bit zlp, input bit rx, input bit rnd);
        int  rem = len;
        bit  fin = 1'b0;
        request(sp, mps, len, zlp, rx);
        chk(req_rej == 1'b0, "R2 accept", req_rej, 0);
        while (!fin) begin
            int el = exp_len(rem, mps);
            int pick = rnd ? int'($urandom % 10) : 0;
            chk(pkt_valid == 1'b1, "R3 valid", pkt_valid, 1);
            chk(int'(pkt_len) == el, "R3 len", pkt_len, el);
            chk(pkt_pid == exp_pid(exp_tog), "R7 pid", pkt_pid, exp_pid(exp_tog));
            if (pick >= 8) begin
                result(pick == 8 ? 2'b01 : 2'b10, 0);
                chk(int'(pkt_len) == el && pkt_pid == exp_pid(exp_tog) && !done_pulse,
                    "R7 retry", pkt_len, el);
            end else begin
                int rl = el;
                bit end_now;
                if (rx && rnd && ($urandom % 4 == 0)) rl = int'($urandom % (el + 1));
                result(2'b00, rl);
                exp_tog = ~exp_tog;
                rem = rem - rl;
                end_now = (rl < mps) || (rem == 0 && !(zlp && !rx));
                if (rx && rl < mps) chk(done_pulse == 1'b1, "R5 short done", done_pulse, 1);
                else if (end_now && el == 0) chk(done_pulse == 1'b1, "R6 zlp done", done_pulse, 1);
                else chk(done_pulse == end_now, "R4 done", done_pulse, int'(end_now));
                chk(pkt_valid == !end_now, "R4 valid after", pkt_valid, int'(!end_now));
                fin = end_now;
            end
        end
        chk(pkt_pid == exp_pid(exp_tog), "R7 pid after", pkt_pid, exp_pid(exp_tog));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_0bb1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pkt_valid == 0 && halted == 0 && done_pulse == 0 && abort_pulse == 0 && req_rej == 0,
            "R1 reset idle", pkt_valid, 0);
        chk(pkt_pid == D0, "R1 reset pid", pkt_pid, D0);

        // R2 size legality
        for (int sp = 0; sp < 4; sp++) begin
            int sizes[6] = '{8, 16, 24, 64, 512, 128};
            foreach (sizes[k]) begin
                speed = 2'(sp); max_pkt = MPS_W'(sizes[k]);
                #0.1;
                chk(cfg_err == !exp_legal(2'(sp), sizes[k]), "R2 cfg_err", cfg_err,
                    int'(!exp_legal(2'(sp), sizes[k])));
            end
        end
        @(negedge clk);
        request(2'b00, 8, 32, 0, 0);
        chk(req_rej == 1 && pkt_valid == 0, "R2 low speed rejected", req_rej, 1);
        request(2'b01, 24, 32, 0, 0);
        chk(req_rej == 1 && pkt_valid == 0, "R2 bad size rejected", req_rej, 1);

        // R11 result while idle
        result(2'b00, 0);
        chk(done_pulse == 0 && abort_pulse == 0 && pkt_pid == D0, "R11 idle ack ignored", done_pulse, 0);
        result(2'b11, 0);
        chk(abort_pulse == 0 && halted == 0, "R11 idle stall ignored", halted, 0);

        // R4 exact multiple, no zlp; R6 zlp variants
        run_xfer(2'b01, 64, 128, 0, 0, 0);
        run_xfer(2'b01, 64, 128, 1, 0, 0);
        run_xfer(2'b01, 32, 0, 0, 0, 0);
        run_xfer(2'b10, 512, 1300, 1, 0, 0);

        // R2 request while busy
        request(2'b01, 8, 40, 0, 0);
        request(2'b01, 8, 40, 0, 0);
        chk(req_rej == 1 && pkt_valid == 1 && int'(pkt_len) == 8, "R2 busy rejected", req_rej, 1);

        // R9 stall, halted, reject, clear
        result(2'b00, 0);
        exp_tog = ~exp_tog;
        result(2'b11, 0);
        chk(abort_pulse == 1 && halted == 1 && pkt_valid == 0, "R9 stall abort", abort_pulse, 1);
        chk(pkt_pid == exp_pid(exp_tog), "R9 pid kept", pkt_pid, exp_pid(exp_tog));
        request(2'b01, 8, 40, 0, 0);
        chk(req_rej == 1 && pkt_valid == 0, "R9 halted rejects", req_rej, 1);
        strobe_clr(1'b0);
        chk(halted == 0 && pkt_pid == D0, "R8 clear halt", pkt_pid, D0);

        // R8 configure resets toggle
        run_xfer(2'b01, 16, 16, 0, 0, 0);
        chk(pkt_pid == D1, "R8 toggled before cfg", pkt_pid, D1);
        strobe_clr(1'b1);
        chk(pkt_pid == D0, "R8 cfg to DATA0", pkt_pid, D0);

        // R10 oversize receive
        request(2'b01, 64, 100, 0, 1);
        result(2'b00, 65);
        chk(abort_pulse == 1 && pkt_valid == 0 && done_pulse == 0, "R10 oversize abort", abort_pulse, 1);
        chk(pkt_pid == D0, "R10 toggle held", pkt_pid, D0);
        request(2'b01, 64, 20, 0, 1);
        result(2'b00, 21);
        chk(abort_pulse == 1 && halted == 0, "R10 oversize last", abort_pulse, 1);

        // R5 short receive
        run_xfer(2'b01, 64, 300, 0, 1, 0);
        request(2'b01, 32, 200, 0, 1);
        result(2'b00, 10);
        exp_tog = ~exp_tog;
        chk(done_pulse == 1 && pkt_valid == 0, "R5 short rx", done_pulse, 1);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            bit hs = ($urandom % 4 == 0);
            int mps = hs ? 512 : (8 << ($urandom % 4));
            int len = int'($urandom % (hs ? 2100 : 400));
            if ($urandom % 5 == 0) len = mps * int'(1 + $urandom % 3);
            run_xfer(hs ? 2'b10 : 2'b01, mps, len, 1'($urandom), 1'($urandom), 1'b1);
            chk(pkt_valid == 0, "R4 idle between", pkt_valid, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule